// File: doc/BRIEF.md
# Temperature-Triggered Oscillator Phase Drift Recalibrator

This sequencer keeps the phase offsets of the middle-band and high-band digital oscillators aligned with the low band as the instrument warms or cools. At factory calibration it latches two reference values. Each one is the phase of the middle or high calibration tone, measured relative to the low-band tone. At that moment it also records the current temperature as its baseline.

In service the block compares every temperature reading with the baseline. When the gap grows past a programmable threshold, a recalibration starts. The block cuts off the user input, switches on the coherent calibration tones and waits a programmable settling time. It then asks an external phase estimator for the tone phase of the low band, then the middle band, then the high band. From these it forms fresh phase differences, compares them with the stored references and writes corrected offsets.

A secondary term is added to both offsets. It is a signed per-degree coefficient times the deviation of the tone oven temperature from its nominal value. If an estimator response is late, the sequence aborts, the old offsets stay in place and an error flag is raised.

Top module: `phase_drift_recal`

## Requirements
- R1: While reset is asserted, busy, meas_req, isolate, tone_en and err are 0, and off_mid and off_high are 0.
- R2: When idle, a recalibration starts on the clock edge at which |temp_now - baseline| is strictly greater than temp_thresh, in either direction. busy is 1 from the following cycle, and the baseline takes the value of temp_now at that edge. A difference equal to the threshold starts nothing.
- R3: A factory_load pulse while idle stores ref_mid_in and ref_high_in, takes temp_now as the baseline and clears both offsets to 0. It has priority over a trigger in the same cycle.
- R4: isolate and tone_en are 1 in every cycle of a sequence and 0 when idle.
- R5: meas_req first rises settle_cycles+1 cycles after busy rises, with meas_band = 0 (low). It stays high while meas_band steps to 1 (middle) and then 2 (high). Each band advances on a clock edge with meas_ack high, and meas_phase is sampled on that edge.
- R6: On the edge of the high-band acknowledgement, off_mid becomes (ref_mid - (ph_mid - ph_low) + corr) mod 4096 and off_high becomes (ref_high - (ph_high - ph_low) + corr) mod 4096. busy falls on the same edge. Offsets change at no other time except on a factory load.
- R7: corr = oven_coef * (oven_temp - oven_ref) mod 4096. oven_coef is two's complement, the temperatures are unsigned, and all three are sampled on the final acknowledgement edge.
- R8: If a requested band gets no acknowledgement within timeout_cycles+1 cycles of request, the sequence aborts. busy, isolate and tone_en drop, err becomes 1, and both offsets keep their previous values.
- R9: err stays set until the next recalibration starts, and it is cleared on that start edge.
- R10: Temperature changes during a sequence neither restart it nor move the baseline. The baseline remains the temperature captured at the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_now | input | TW | Current board temperature, unsigned |
| temp_thresh | input | TW | Trigger threshold on the temperature change |
| settle_cycles | input | NW | Tone settling wait |
| timeout_cycles | input | NW | Acknowledgement timeout per band |
| factory_load | input | 1 | Store references and baseline |
| ref_mid_in | input | PW | Factory middle-to-low tone phase difference |
| ref_high_in | input | PW | Factory high-to-low tone phase difference |
| oven_temp | input | TW | Tone oven temperature |
| oven_ref | input | TW | Nominal oven temperature |
| oven_coef | input | CW | Signed secondary-correction coefficient per degree |
| meas_req | output | 1 | Phase measurement request |
| meas_band | output | 2 | Band to measure: 0 low, 1 middle, 2 high |
| meas_ack | input | 1 | Estimator acknowledgement, meas_phase valid |
| meas_phase | input | PW | Measured tone phase, fraction of a cycle |
| isolate | output | 1 | Disconnect user input |
| tone_en | output | 1 | Enable calibration tones |
| busy | output | 1 | Recalibration in progress |
| err | output | 1 | Last sequence timed out |
| off_mid | output | PW | Middle-band oscillator phase offset |
| off_high | output | PW | High-band oscillator phase offset |

## Verification
A temperature step that crosses the threshold shows up as busy, isolate and tone_en one cycle after the edge that sees it. The first request follows settle_cycles+1 cycles later. The bench counts falling edges from busy to meas_req and compares that count with the settle setting.

New offsets and the fall of busy are due on the same edge that accepts the high-band acknowledgement, so the bench reads them at the very next falling edge. A missing acknowledgement holds the request for exactly timeout_cycles+1 cycles before the abort, and the bench counts those cycles directly.

Expected offsets come from modular arithmetic on the phases the bench itself supplies. The sweep covers wrapping drifts, both signs of the coefficient and several settle lengths.

// File: rtl/phase_drift_recal.sv
module phase_drift_recal #(
  parameter int TW = 10,
  parameter int PW = 12,
  parameter int CW = 8,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_now,
  input  logic [TW-1:0] temp_thresh,
  input  logic [NW-1:0] settle_cycles,
  input  logic [NW-1:0] timeout_cycles,
  input  logic          factory_load,
  input  logic [PW-1:0] ref_mid_in,
  input  logic [PW-1:0] ref_high_in,
  input  logic [TW-1:0] oven_temp,
  input  logic [TW-1:0] oven_ref,
  input  logic [CW-1:0] oven_coef,
  output logic          meas_req,
  output logic [1:0]    meas_band,
  input  logic          meas_ack,
  input  logic [PW-1:0] meas_phase,
  output logic          isolate,
  output logic          tone_en,
  output logic          busy,
  output logic          err,
  output logic [PW-1:0] off_mid,
  output logic [PW-1:0] off_high
);
  typedef enum logic [2:0] {IDLE, SETTLE, M_LO, M_MID, M_HI} state_t;
  state_t st;

  logic [NW-1:0] cnt;
  logic [TW-1:0] base, tdelta;
  logic [PW-1:0] ref_mid, ref_high, ph_lo, ph_mid;
  logic [PW-1:0] dev, coefx, corr, nxt_mid, nxt_high;
  logic          trig;

  assign busy      = (st != IDLE);
  assign isolate   = busy;
  assign tone_en   = busy;
  assign meas_req  = (st == M_LO) || (st == M_MID) || (st == M_HI);
  assign meas_band = (st == M_MID) ? 2'd1 : (st == M_HI) ? 2'd2 : 2'd0;

  assign tdelta = (temp_now >= base) ? temp_now - base : base - temp_now;
  assign trig   = tdelta > temp_thresh;

  assign dev      = {{(PW-TW){1'b0}}, oven_temp} - {{(PW-TW){1'b0}}, oven_ref};
  assign coefx    = {{(PW-CW){oven_coef[CW-1]}}, oven_coef};
  assign corr     = dev * coefx;
  assign nxt_mid  = ref_mid - (ph_mid - ph_lo) + corr;
  assign nxt_high = ref_high - (meas_phase - ph_lo) + corr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      base     <= '0;
      ref_mid  <= '0;
      ref_high <= '0;
      ph_lo    <= '0;
      ph_mid   <= '0;
      off_mid  <= '0;
      off_high <= '0;
      err      <= 1'b0;
    end else begin
      case (st)
        IDLE: begin
          if (factory_load) begin
            ref_mid  <= ref_mid_in;
            ref_high <= ref_high_in;
            base     <= temp_now;
            off_mid  <= '0;
            off_high <= '0;
          end else if (trig) begin
            base <= temp_now;
            err  <= 1'b0;
            cnt  <= '0;
            st   <= SETTLE;
          end
        end
        SETTLE: begin
          if (cnt >= settle_cycles) begin
            cnt <= '0;
            st  <= M_LO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (meas_ack) begin
            cnt <= '0;
            case (st)
              M_LO: begin
                ph_lo <= meas_phase;
                st    <= M_MID;
              end
              M_MID: begin
                ph_mid <= meas_phase;
                st     <= M_HI;
              end
              default: begin
                off_mid  <= nxt_mid;
                off_high <= nxt_high;
                st       <= IDLE;
              end
            endcase
          end else if (cnt >= timeout_cycles) begin
            err <= 1'b1;
            st  <= IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module phase_drift_recal_chk #(
  parameter int PW = 12,
  parameter int NW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          meas_req,
  input logic [1:0]    meas_band,
  input logic          err,
  input logic          factory_load,
  input logic [NW-1:0] settle_cycles,
  input logic [PW-1:0] off_mid,
  input logic [PW-1:0] off_high
);
  localparam logic [NW:0] ONE = 1;
  logic [NW:0] sc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sc <= '0;
    else if (!busy)    sc <= '0;
    else if (!meas_req) sc <= sc + ONE;
  end

  assert_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_req) |-> (sc == {1'b0, settle_cycles} + ONE) && (meas_band == 2'd0));

  assert_band_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && $past(meas_req) && (meas_band != $past(meas_band)))
      |-> (meas_band == $past(meas_band) + 2'd1));

  assert_off_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(off_mid) || !$stable(off_high)) |-> ($fell(busy) || $past(factory_load)));

  assert_abort_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($fell(busy) && $stable(off_mid) && $stable(off_high)));

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $rose(busy));
endmodule

bind phase_drift_recal phase_drift_recal_chk #(.PW(PW), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .meas_req(meas_req), .meas_band(meas_band),
  .err(err), .factory_load(factory_load), .settle_cycles(settle_cycles),
  .off_mid(off_mid), .off_high(off_high)
);

// File: tb/phase_drift_recal_bench.sv
`timescale 1ns/1ps
module phase_drift_recal_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [9:0]  temp_now = '0, temp_thresh = 10'd5, oven_temp = 10'd300, oven_ref = 10'd300;
  logic [15:0] settle_cycles = 16'd3, timeout_cycles = 16'd10;
  logic        factory_load = 1'b0;
  logic [11:0] ref_mid_in = '0, ref_high_in = '0;
  logic [7:0]  oven_coef = '0;
  logic        meas_req, meas_ack = 1'b0;
  logic [1:0]  meas_band;
  logic [11:0] meas_phase = '0;
  logic        isolate, tone_en, busy, err;
  logic [11:0] off_mid, off_high;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int base = 100, rmid = 0, rhigh = 0, corr = 0;

  phase_drift_recal u_phase_drift_recal (
    .clk(clk), .rst_n(rst_n), .temp_now(temp_now), .temp_thresh(temp_thresh),
    .settle_cycles(settle_cycles), .timeout_cycles(timeout_cycles),
    .factory_load(factory_load), .ref_mid_in(ref_mid_in), .ref_high_in(ref_high_in),
    .oven_temp(oven_temp), .oven_ref(oven_ref), .oven_coef(oven_coef),
    .meas_req(meas_req), .meas_band(meas_band), .meas_ack(meas_ack), .meas_phase(meas_phase),
    .isolate(isolate), .tone_en(tone_en), .busy(busy), .err(err),
    .off_mid(off_mid), .off_high(off_high)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic serve(int pl, int pm, int ph, int dly);
    for (int b = 0; b < 3; b++) begin
      while (!meas_req) @(negedge clk);
      chk("R5 band order", int'(meas_band), b);
      repeat (dly) @(negedge clk);
      meas_phase = 12'((b == 0) ? pl : (b == 1) ? pm : ph);
      meas_ack = 1'b1;
      @(negedge clk);
      meas_ack = 1'b0;
    end
  endtask

  task automatic run(int t, int pl, int dm, int dh, int dly);
    int k = 0;
    temp_now = 10'(t);
    @(negedge clk);
    chk("R2 trigger busy", int'(busy), 1);
    chk("R4 isolate on", int'(isolate), 1);
    chk("R4 tone on", int'(tone_en), 1);
    chk("R9 err cleared at start", int'(err), 0);
    while (!meas_req) begin @(negedge clk); k++; end
    chk("R5 settle length", k, int'(settle_cycles) + 1);
    serve(pl, (pl + rmid + dm) & 4095, (pl + rhigh + dh) & 4095, dly);
    chk("R6 R7 off_mid", int'(off_mid), (corr - dm) & 4095);
    chk("R6 R7 off_high", int'(off_high), (corr - dh) & 4095);
    chk("R6 busy falls", int'(busy), 0);
    chk("R4 isolate off", int'(isolate), 0);
    chk("R4 tone off", int'(tone_en), 0);
    base = t;
  endtask

  initial begin
    int t0, t, k, om, oh;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 meas_req", int'(meas_req), 0);
    chk("R1 isolate", int'(isolate), 0);
    chk("R1 tone_en", int'(tone_en), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 off_mid", int'(off_mid), 0);
    chk("R1 off_high", int'(off_high), 0);
    rst_n = 1'b1;
    @(negedge clk);

    rmid = 1000; rhigh = 3000;
    ref_mid_in = 12'(rmid); ref_high_in = 12'(rhigh);
    temp_now = 10'(base); factory_load = 1'b1;
    @(negedge clk);
    factory_load = 1'b0;
    @(negedge clk);
    chk("R3 no trigger after load", int'(busy), 0);

    temp_now = 10'(base + 5);
    repeat (4) @(negedge clk);
    chk("R2 equal threshold up", int'(busy), 0);
    temp_now = 10'(base - 5);
    repeat (4) @(negedge clk);
    chk("R2 equal threshold down", int'(busy), 0);

    for (int i = 0; i < 24; i++) begin
      int coef, od, dir;
      settle_cycles = 16'((i % 4) * 2);
      coef = (i % 7) - 3;
      od = (i % 5) * 7 - 14;
      oven_temp = 10'(300 + od);
      oven_coef = 8'(coef);
      corr = coef * od;
      dir = (i % 2) ? -1 : 1;
      run(base + dir * (6 + (i % 3)), (i * 397) % 4096, (i * 700 + 4000) % 4096,
          (i * 1111 + 50) % 4096, i % 3);
    end

    // R10: temperature moves during the sequence
    settle_cycles = 16'd4;
    t0 = base; t = t0 + 6;
    temp_now = 10'(t);
    @(negedge clk);
    chk("R10 start", int'(busy), 1);
    temp_now = 10'(t0 + 30);
    k = 0;
    while (!meas_req) begin @(negedge clk); k++; end
    chk("R10 no restart", k, 5);
    temp_now = 10'(t + 2);
    serve(123, (123 + rmid + 9) & 4095, (123 + rhigh + 4090) & 4095, 1);
    chk("R10 R6 off_mid", int'(off_mid), (corr - 9) & 4095);
    chk("R10 R6 off_high", int'(off_high), (corr - 4090) & 4095);
    repeat (4) @(negedge clk);
    chk("R10 baseline kept", int'(busy), 0);
    base = t;

    // R8: timeout on the middle band
    t = base + 7;
    om = int'(off_mid); oh = int'(off_high);
    temp_now = 10'(t);
    @(negedge clk);
    chk("R8 start", int'(busy), 1);
    while (!meas_req) @(negedge clk);
    meas_phase = 12'd55; meas_ack = 1'b1;
    @(negedge clk);
    meas_ack = 1'b0;
    k = 0;
    while (busy) begin
      if (meas_req && meas_band == 2'd1) k++;
      @(negedge clk);
    end
    chk("R8 request length", k, int'(timeout_cycles) + 1);
    chk("R8 err set", int'(err), 1);
    chk("R8 off_mid kept", int'(off_mid), om);
    chk("R8 off_high kept", int'(off_high), oh);
    chk("R8 isolate off", int'(isolate), 0);
    repeat (3) @(negedge clk);
    chk("R9 err held", int'(err), 1);
    base = t;

    run(base - 6, 2000, 17, 3333, 0);
    chk("R9 err after good run", int'(err), 0);

    // R3: reload references at a new baseline
    rmid = 77; rhigh = 4000;
    ref_mid_in = 12'(rmid); ref_high_in = 12'(rhigh);
    temp_now = 10'd200; factory_load = 1'b1;
    @(negedge clk);
    factory_load = 1'b0;
    chk("R3 off_mid cleared", int'(off_mid), 0);
    chk("R3 off_high cleared", int'(off_high), 0);
    @(negedge clk);
    chk("R3 load priority", int'(busy), 0);
    base = 200;
    temp_now = 10'd205;
    repeat (4) @(negedge clk);
    chk("R3 R2 new baseline", int'(busy), 0);
    run(194, 4000, 300, 2500, 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1;
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule